// File: doc/BRIEF.md
# Printer-Style Parallel Port Controller

This block is the host side of a standard byte-wide parallel port, seen by software through a small register bus. The registers are an output data latch, a status register and a control register. The block answers like a simple printer attached to the port. Writing the control register with a strobe pulse hands the latched output byte to a valid/ready byte stream. Reads of the status register step the busy and acknowledge bits the way a printer's handshake would.

A separate input latch samples the incoming data pins on every clock. The direction bit of the control register chooses which latch a data read returns. When its enable bit is set, the block raises an active-high interrupt line after a byte is accepted. A status read clears the interrupt. All register side effects take place at the clock edge that ends the access. Read data is combinational and shows the register contents from before that edge.

Top module: `pport_ctrl`

## Requirements
- R1: After reset the status register reads 0xD9 (bits 7, 6, 4, 3 and 0 set). The control register reads 0x0C (bits 3 and 2 set). The output latch is 0x00, and both tx_valid and irq are low.
- R2: Offset 0 selects the data register, offset 1 the status register and offset 2 the control register. A read from any offset from 3 to 7 returns 0xFF. A write to those offsets changes no register.
- R3: A data read returns the input latch when control bit 5 (direction) is 1, and the output latch when it is 0. The input latch holds pin_data_in as sampled at the previous clock edge.
- R4: A control write with bit 2 (init) at 0 sets the status register to 0xD8: busy-complement bit 7, ack bit 6, online bit 4 and error-complement bit 3 set, all other bits clear.
- R5: A control write with bits 2, 3 and 0 (init, select, strobe) all at 1 clears status bit 7. If the previous control value had bit 0 clear and the stream slot is empty, the output latch is sent once on the byte stream.
- R6: A status read with status bit 7 clear and control bit 0 clear toggles status bit 6. When bit 6 becomes set, bit 7 is set along with it.
- R7: Once tx_valid is high, it stays high and tx_data stays stable until tx_ready is seen. A send attempted while the slot is occupied is dropped.
- R8: A write meeting the conditions of R5 sets the pending interrupt flag if control bit 4 was 1 before the write. irq goes high one cycle after the flag and enable are both set. A status read clears the flag.
- R9: Writes to the status register are ignored.
- R10: pin_ctl carries control bits 3 to 0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pin_data_in | input | 8 | Incoming data pins |
| pin_data_out | output | 8 | Output data latch |
| pin_ctl | output | 4 | Low control bits to the peripheral |
| tx_valid | output | 1 | Stream byte available |
| tx_ready | input | 1 | Stream consumer accepts the byte |
| tx_data | output | 8 | Stream byte |
| irq | output | 1 | Interrupt, active high, registered |

## Verification
The handshake is driven through a full strobe cycle and then a series of status reads. This separates the busy-clear caused by the strobe from the acknowledge toggle caused by the reads, and shows that the reads change nothing while the strobe bit is still high. Control writes with init low are mixed with writes that have init high and select high but strobe low. This shows that only the first kind forces the status value. Data reads are taken with both direction settings, using a latched output byte that differs from the input pins. A second strobe is sent while the stream slot is still full, and interrupts are tried with the enable bit both clear and set. Together these show the drop rule and the gating of the interrupt.

// File: rtl/pport_pkg.sv
package pport_pkg;

    localparam int BYTE_W = 8;

    localparam int OFF_DATA = 0;
    localparam int OFF_STAT = 1;
    localparam int OFF_CTRL = 2;

    localparam int ST_BUSY_N = 7;
    localparam int ST_ACK    = 6;

    localparam int CT_DIR    = 5;
    localparam int CT_IEN    = 4;
    localparam int CT_SEL    = 3;
    localparam int CT_INIT   = 2;
    localparam int CT_STB    = 0;

    localparam logic [BYTE_W-1:0] STAT_RESET  = 8'hD9;
    localparam logic [BYTE_W-1:0] STAT_FORCED = 8'hD8;
    localparam logic [BYTE_W-1:0] CTRL_RESET  = 8'h0C;
    localparam logic [BYTE_W-1:0] OPEN_READ   = 8'hFF;

    typedef struct packed {
        logic [BYTE_W-1:0] stat;
        logic [BYTE_W-1:0] ctl;
        logic [BYTE_W-1:0] dout;
        logic [BYTE_W-1:0] din;
        logic              pend;
    } regs_t;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } slot_t;

endpackage

// File: rtl/pport_regfile.sv
module pport_regfile
    import pport_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] pin_din,
    output logic [BYTE_W-1:0] rdata,
    output logic [BYTE_W-1:0] stat_q,
    output logic [BYTE_W-1:0] ctl_q,
    output logic [BYTE_W-1:0] dout_q,
    output logic              pend_q,
    output logic              send
);

    regs_t r_d, r_q;

    logic is_data, is_stat, is_ctrl;

    always_comb begin
        is_data = (addr == ADDR_W'(OFF_DATA));
        is_stat = (addr == ADDR_W'(OFF_STAT));
        is_ctrl = (addr == ADDR_W'(OFF_CTRL));
    end

    always_comb begin
        r_d   = r_q;
        send  = 1'b0;
        r_d.din = pin_din;
        if (acc && wr) begin
            if (is_data) begin
                r_d.dout = wdata;
            end else if (is_ctrl) begin
                r_d.ctl = wdata;
                if (!wdata[CT_INIT]) begin
                    r_d.stat = STAT_FORCED;
                end else if (wdata[CT_SEL] && wdata[CT_STB]) begin
                    r_d.stat[ST_BUSY_N] = 1'b0;
                    send = !r_q.ctl[CT_STB];
                    if (r_q.ctl[CT_IEN]) begin
                        r_d.pend = 1'b1;
                    end
                end
            end
        end else if (acc && is_stat) begin
            r_d.pend = 1'b0;
            if (!r_q.stat[ST_BUSY_N] && !r_q.ctl[CT_STB]) begin
                if (r_q.stat[ST_ACK]) begin
                    r_d.stat[ST_ACK] = 1'b0;
                end else begin
                    r_d.stat[ST_ACK]    = 1'b1;
                    r_d.stat[ST_BUSY_N] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.stat <= STAT_RESET;
            r_q.ctl  <= CTRL_RESET;
            r_q.dout <= '0;
            r_q.din  <= '0;
            r_q.pend <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        if (is_data) begin
            rdata = r_q.ctl[CT_DIR] ? r_q.din : r_q.dout;
        end else if (is_stat) begin
            rdata = r_q.stat;
        end else if (is_ctrl) begin
            rdata = r_q.ctl;
        end else begin
            rdata = OPEN_READ;
        end
    end

    assign stat_q = r_q.stat;
    assign ctl_q  = r_q.ctl;
    assign dout_q = r_q.dout;
    assign pend_q = r_q.pend;

endmodule

// File: rtl/pport_txslot.sv
module pport_txslot
    import pport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send,
    input  logic [BYTE_W-1:0] send_data,
    input  logic              ready,
    output logic              valid,
    output logic [BYTE_W-1:0] data
);

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.valid) begin
            if (ready) begin
                s_d.valid = 1'b0;
            end
        end else if (send) begin
            s_d.valid = 1'b1;
            s_d.data  = send_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign valid = s_q.valid;
    assign data  = s_q.data;

endmodule

// File: rtl/pport_irqgen.sv
module pport_irqgen #(
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pend,
    input  logic enable,
    output logic irq
);

    logic req_d, req_q;

    always_comb req_d = pend && enable;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= req_d;
        end
    end

    generate
        if (ACTIVE_HIGH) begin : g_high
            assign irq = req_q;
        end else begin : g_low
            assign irq = !req_q;
        end
    endgenerate

endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
    import pport_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [7:0]        pin_data_in,
    output logic [7:0]        pin_data_out,
    output logic [3:0]        pin_ctl,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              irq
);

    logic [BYTE_W-1:0] stat_q, ctl_q, dout_q;
    logic              pend_q, send;

    pport_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (bus_sel),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .pin_din (pin_data_in),
        .rdata   (bus_rdata),
        .stat_q  (stat_q),
        .ctl_q   (ctl_q),
        .dout_q  (dout_q),
        .pend_q  (pend_q),
        .send    (send)
    );

    pport_txslot u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .send      (send),
        .send_data (dout_q),
        .ready     (tx_ready),
        .valid     (tx_valid),
        .data      (tx_data)
    );

    pport_irqgen #(.ACTIVE_HIGH(1'b1)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend   (pend_q),
        .enable (ctl_q[CT_IEN]),
        .irq    (irq)
    );

    assign pin_data_out = dout_q;
    assign pin_ctl      = ctl_q[3:0];

endmodule

// File: rtl/pport_chk.sv
module pport_chk #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic [7:0]        pin_data_out,
    input logic [7:0]        stat_q,
    input logic [7:0]        ctl_q,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_data,
    input logic              irq
);

    p_open_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr > ADDR_W'(2)) |-> bus_rdata == 8'hFF);

    p_data_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(0)) |=> pin_data_out == $past(bus_wdata));

    p_init_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(2) && !bus_wdata[2]) |=> stat_q == 8'hD8);

    p_send_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(2) && bus_wdata[2] && bus_wdata[3]
         && bus_wdata[0] && !ctl_q[0] && !tx_valid)
        |=> tx_valid && tx_data == $past(pin_data_out) && !stat_q[7]);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data));

    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ctl_q[4]));

    p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == ADDR_W'(1)) |-> ##2 !irq);

    p_stat_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(1)) |=> $stable(stat_q));

endmodule

bind pport_ctrl pport_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .pin_data_out (pin_data_out),
    .stat_q       (stat_q),
    .ctl_q        (ctl_q),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .tx_data      (tx_data),
    .irq          (irq)
);

// File: tb/pport_ctrl_test.sv
`timescale 1ns/1ps
module pport_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_data_in = 8'hA5;
    logic [7:0] pin_data_out;
    logic [3:0] pin_ctl;
    logic       tx_valid;
    logic       tx_ready = 1'b0;
    logic [7:0] tx_data;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] rd;

    always #2 clk = ~clk;

    pport_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_data_in(pin_data_in), .pin_data_out(pin_data_out), .pin_ctl(pin_ctl),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .irq(irq)
    );

    // {write, offset, data, expected read}
    localparam int NV = 21;
    localparam logic [19:0] VEC [NV] = '{
        {1'b0, 3'd2, 8'h00, 8'h0C},   // R1 control reset value
        {1'b0, 3'd1, 8'h00, 8'hD9},   // R1 status reset value
        {1'b1, 3'd0, 8'h3C, 8'h00},
        {1'b0, 3'd0, 8'h00, 8'h3C},   // R3 direction 0 -> output latch
        {1'b1, 3'd2, 8'h2C, 8'h00},
        {1'b0, 3'd0, 8'h00, 8'hA5},   // R3 direction 1 -> input latch
        {1'b1, 3'd2, 8'h0C, 8'h00},
        {1'b1, 3'd2, 8'h0D, 8'h00},   // R5 strobe high
        {1'b0, 3'd1, 8'h00, 8'h59},   // R5 busy cleared, R6 no toggle with strobe high
        {1'b1, 3'd2, 8'h0C, 8'h00},
        {1'b0, 3'd1, 8'h00, 8'h59},   // R6 read clears ack
        {1'b0, 3'd1, 8'h00, 8'h19},   // R6 read sets ack and busy
        {1'b0, 3'd1, 8'h00, 8'hD9},   // R6 result
        {1'b1, 3'd1, 8'h00, 8'h00},   // R9 status write
        {1'b0, 3'd1, 8'h00, 8'hD9},   // R9 status unchanged
        {1'b0, 3'd5, 8'h00, 8'hFF},   // R2 open offset read
        {1'b1, 3'd5, 8'h77, 8'h00},   // R2 open offset write
        {1'b0, 3'd0, 8'h00, 8'h3C},   // R2 data untouched
        {1'b1, 3'd2, 8'h08, 8'h00},
        {1'b0, 3'd1, 8'h00, 8'hD8},   // R4 forced status
        {1'b0, 3'd2, 8'h00, 8'h08}    // R2 control read back
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic op(input logic w, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
        #1 rd = bus_rdata;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R1 data out", pin_data_out, 8'h00);
        check("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            op(VEC[i][19], VEC[i][18:16], VEC[i][15:8]);
            if (!VEC[i][19]) check($sformatf("table row %0d", i), rd, VEC[i][7:0]);
        end

        // R5/R7: first strobe emitted 0x3C and is still held
        check("R5 emitted byte", tx_data, 8'h3C);
        check("R7 held valid", {7'b0, tx_valid}, 8'h01);

        // R7: second send while full is dropped
        op(1'b1, 3'd2, 8'h0C);
        op(1'b1, 3'd0, 8'h55);
        op(1'b1, 3'd2, 8'h0D);
        check("R10 pin_ctl", {4'b0, pin_ctl}, 8'h0D);
        check("R7 drop keeps data", tx_data, 8'h3C);
        @(negedge clk) tx_ready = 1'b1;
        @(posedge clk); #1 tx_ready = 1'b0;
        check("R7 drained", {7'b0, tx_valid}, 8'h00);

        // R8: enable clear -> no interrupt
        op(1'b1, 3'd2, 8'h0C);
        op(1'b1, 3'd2, 8'h0D);
        @(posedge clk); #1;
        check("R8 no irq when disabled", {7'b0, irq}, 8'h00);
        check("R5 second byte", tx_data, 8'h55);
        @(negedge clk) tx_ready = 1'b1;
        @(posedge clk); #1 tx_ready = 1'b0;

        // R8: enable set -> interrupt, then cleared by status read
        op(1'b1, 3'd2, 8'h1C);
        op(1'b1, 3'd2, 8'h1D);
        @(posedge clk); #1;
        check("R8 irq raised", {7'b0, irq}, 8'h01);
        op(1'b0, 3'd1, 8'h00);
        @(posedge clk); #1;
        check("R8 irq cleared", {7'b0, irq}, 8'h00);

        // R3: input latch follows new pin value
        pin_data_in = 8'h6E;
        op(1'b1, 3'd2, 8'h2C);
        op(1'b0, 3'd0, 8'h00);
        check("R3 new input", rd, 8'h6E);

        summary();
    end

endmodule